// File: doc/BRIEF.md
# Mailbox Command Requester Sequencer

The block sends commands, one at a time, to a power-management controller. The controller is reached through three memory-mapped mailbox registers: a message-ID register, a parameter register and a response register. A local requester presents a command ID and a 32-bit argument. The sequencer then works through the mailbox protocol on a simple valid/ready read/write master port. It waits until the mailbox reports idle, which is any nonzero response. It clears the response, writes the argument, and writes the ID last, because that write starts the transaction. It then polls the response again and returns the final response code together with a result word.

Polling runs at a runtime-programmable interval, counted in core clock cycles, and under a runtime retry budget. A debug input removes the budget so that polling never gives up. There are three special paths. A failed response re-arms the mailbox by writing OK into the response register. A post-issue timeout buys one more full polling wait. A deasserted `present` input turns every request into an immediate, traffic-free completion.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset `reqReady` is 1, `doneValid` is 0 and `busValid` is 0.
- R2: Before issuing, the block reads the response register (address `RSP_ADDR`, default 0x18) until it returns a nonzero word. Any nonzero value counts as idle, including codes other than 0x01. With the bus always ready, consecutive response reads start `pollInterval`+1 cycles apart. At most `pollRetries`+1 reads are made in one wait.
- R3: If all `pollRetries`+1 pre-issue reads return zero, the command ends with no bus write and no parameter read. The completion reports `doneCode`=0x00, `doneResult`=0 and `doneTimeout`=1.
- R4: The issue writes are, in this order: 0 to `RSP_ADDR`, then the argument to `ARG_ADDR` (0x14), then the zero-extended command ID to `MSG_ADDR` (0x10).
- R5: After the ID write, the response register is polled with the same interval and budget. If the wait ends with a nonzero code other than 0xFF, `doneCode` is the low 8 bits of that response. The parameter register is then read once, and the word read is returned in `doneResult`, with `doneTimeout`=0.
- R6: A 0xFF response in the first post-issue wait causes one extra write of 0x01 to `RSP_ADDR`, made after the three issue writes. No parameter read follows. The completion reports `doneCode`=0xFF and `doneResult`=0.
- R7: If the first post-issue wait times out, one more full wait follows, and `doneTimeout` is set to 1. `doneCode` is the nonzero value that ends the second wait, or 0x00 if that wait also times out. The parameter read still follows, and no re-arm write is made.
- R8: With `noTimeout`=1 the retry budget is ignored. Polling continues past `pollRetries`+1 reads until a nonzero response arrives.
- R9: With `present`=0, a request accepted on one edge gives `doneValid`=1 in the following cycle. That completion reports `doneCode`=0x01, `doneResult`=0 and `doneTimeout`=0, and there is no bus transaction.
- R10: `reqReady` is 0 from the accepting edge until `doneValid` has been seen. `doneValid` lasts one cycle, and `reqReady` returns to 1 in the next cycle.
- R11: A bus request held with `busReady`=0 keeps its address, direction and write data unchanged until it is accepted. Stalls change no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer free to accept a request |
| reqCmd | input | CMD_W | Command ID |
| reqArg | input | DATA_W | Command argument |
| present | input | 1 | Controller present; 0 gives immediate completion |
| noTimeout | input | 1 | Debug: poll without a retry limit |
| pollInterval | input | IVL_W | Cycles between polls minus one |
| pollRetries | input | RTY_W | Retry budget per wait |
| busValid | output | 1 | Bus request valid |
| busReady | input | 1 | Bus accepts request this cycle |
| busWrite | output | 1 | 1 write, 0 read |
| busAddr | output | ADDR_W | Mailbox register address |
| busWdata | output | DATA_W | Write data |
| busRdata | input | DATA_W | Read data, valid in the accepting cycle |
| doneValid | output | 1 | One-cycle completion pulse |
| doneCode | output | CODE_W | Final response code |
| doneResult | output | DATA_W | Result word |
| doneTimeout | output | 1 | A polling wait timed out |

## Verification
The bench sweeps how many zero reads the modelled controller gives before and after the trigger, against each response code and several poll intervals, with a budget of two retries. This separates the plain path, the pre-issue timeout, a post-issue timeout that recovers in the second wait, and a timeout in both waits. The 0xFF code is set apart from the other nonzero codes by the re-arm write and the missing parameter read. Read-to-read spacing is checked against the interval. Further runs cover the unlimited-polling debug input, an absent controller, a non-OK idle value seen before issue, and random bus stalls, which must leave every result unchanged.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

  localparam logic [7:0] RSP_OK   = 8'h01;
  localparam logic [7:0] RSP_FAIL = 8'hFF;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD_RSP,
    OP_WR_CLR,
    OP_WR_ARG,
    OP_WR_MSG,
    OP_WR_REARM,
    OP_RD_ARG
  } busOp_e;

  typedef struct packed {
    busOp_e op;
    logic   latchReq;
    logic   clearOut;
    logic   setOk;
    logic   loadRetry;
    logic   decRetry;
    logic   loadGap;
    logic   decGap;
    logic   latchCode;
    logic   latchResult;
    logic   setTimeout;
  } ctlStrobes_t;

endpackage

// File: rtl/mbox_seq_dp.sv
module mbox_seq_dp
  import mbox_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CODE_W = 8,
  parameter int CMD_W  = 8,
  parameter int IVL_W  = 16,
  parameter int RTY_W  = 24,
  parameter logic [ADDR_W-1:0] MSG_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] ARG_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] RSP_ADDR = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [DATA_W-1:0] reqArg,
  input  logic [IVL_W-1:0]  pollInterval,
  input  logic [RTY_W-1:0]  pollRetries,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              retryZero,
  output logic              gapZero,
  output logic              ivlZero,
  output logic              rspNonZero,
  output logic              rspIsFail,
  output logic [CODE_W-1:0] doneCode,
  output logic [DATA_W-1:0] doneResult,
  output logic              doneTimeout
);

  localparam logic [DATA_W-1:0] OK_WORD = DATA_W'(RSP_OK);

  logic [CMD_W-1:0]  cmdQ;
  logic [DATA_W-1:0] argQ;
  logic [RTY_W-1:0]  retryCnt;
  logic [IVL_W-1:0]  gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= '0;
      argQ <= '0;
    end else if (strb.latchReq) begin
      cmdQ <= reqCmd;
      argQ <= reqArg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCnt <= '0;
    end else if (strb.loadRetry) begin
      retryCnt <= pollRetries;
    end else if (strb.decRetry) begin
      retryCnt <= retryCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strb.loadGap) begin
      gapCnt <= pollInterval - 1'b1;
    end else if (strb.decGap) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneCode    <= '0;
      doneResult  <= '0;
      doneTimeout <= 1'b0;
    end else begin
      if (strb.clearOut) begin
        doneCode    <= '0;
        doneResult  <= '0;
        doneTimeout <= 1'b0;
      end
      if (strb.setOk)       doneCode    <= CODE_W'(RSP_OK);
      if (strb.latchCode)   doneCode    <= busRdata[CODE_W-1:0];
      if (strb.latchResult) doneResult  <= busRdata;
      if (strb.setTimeout)  doneTimeout <= 1'b1;
    end
  end

  assign retryZero  = (retryCnt == '0);
  assign gapZero    = (gapCnt == '0);
  assign ivlZero    = (pollInterval == '0);
  assign rspNonZero = (busRdata != '0);
  assign rspIsFail  = (busRdata[CODE_W-1:0] == CODE_W'(RSP_FAIL));

  always_comb begin
    busWrite = 1'b0;
    busAddr  = RSP_ADDR;
    busWdata = '0;
    case (strb.op)
      OP_WR_CLR:   begin busWrite = 1'b1; busAddr = RSP_ADDR; busWdata = '0; end
      OP_WR_ARG:   begin busWrite = 1'b1; busAddr = ARG_ADDR; busWdata = argQ; end
      OP_WR_MSG:   begin busWrite = 1'b1; busAddr = MSG_ADDR; busWdata = DATA_W'(cmdQ); end
      OP_WR_REARM: begin busWrite = 1'b1; busAddr = RSP_ADDR; busWdata = OK_WORD; end
      OP_RD_ARG:   begin busAddr = ARG_ADDR; end
      default:     begin busAddr = RSP_ADDR; end
    endcase
  end

  // R2: the gap counter is never stepped below zero
  assert_gap_no_underflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.decGap |-> !gapZero);

  // R3: the retry budget is never stepped below zero
  assert_retry_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.decRetry |-> !retryZero);

  // R5: a latched code always comes from a nonzero response
  assert_code_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchCode |=> (doneCode != '0));

endmodule

// File: rtl/mbox_seq_ctl.sv
module mbox_seq_ctl
  import mbox_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        present,
  input  logic        noTimeout,
  input  logic        busReady,
  output logic        busValid,
  input  logic        retryZero,
  input  logic        gapZero,
  input  logic        ivlZero,
  input  logic        rspNonZero,
  input  logic        rspIsFail,
  output logic        doneValid,
  output ctlStrobes_t strb
);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RD, S_PRE_GAP, S_CLR, S_ARG, S_MSG,
    S_POST_RD, S_POST_GAP, S_REARM, S_PARAM, S_DONE
  } state_e;

  state_e state, stateNext;
  logic   secondWait, secondSet, secondClr;
  logic   budgetOut;

  assign budgetOut = retryZero && !noTimeout;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      secondWait <= 1'b0;
    end else begin
      state <= stateNext;
      if (secondClr)      secondWait <= 1'b0;
      else if (secondSet) secondWait <= 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    strb.op   = OP_NONE;
    secondSet = 1'b0;
    secondClr = 1'b0;
    reqReady  = 1'b0;
    doneValid = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          strb.clearOut = 1'b1;
          if (!present) begin
            strb.setOk = 1'b1;
            stateNext  = S_DONE;
          end else begin
            strb.loadRetry = 1'b1;
            stateNext      = S_PRE_RD;
          end
        end
      end
      S_PRE_RD: begin
        strb.op = OP_RD_RSP;
        if (busReady) begin
          if (rspNonZero) begin
            stateNext = S_CLR;
          end else if (budgetOut) begin
            strb.setTimeout = 1'b1;
            stateNext       = S_DONE;
          end else begin
            strb.decRetry = !noTimeout;
            strb.loadGap  = !ivlZero;
            stateNext     = ivlZero ? S_PRE_RD : S_PRE_GAP;
          end
        end
      end
      S_PRE_GAP: begin
        if (gapZero) stateNext = S_PRE_RD;
        else strb.decGap = 1'b1;
      end
      S_CLR: begin
        strb.op = OP_WR_CLR;
        if (busReady) stateNext = S_ARG;
      end
      S_ARG: begin
        strb.op = OP_WR_ARG;
        if (busReady) stateNext = S_MSG;
      end
      S_MSG: begin
        strb.op = OP_WR_MSG;
        if (busReady) begin
          strb.loadRetry = 1'b1;
          secondClr      = 1'b1;
          stateNext      = S_POST_RD;
        end
      end
      S_POST_RD: begin
        strb.op = OP_RD_RSP;
        if (busReady) begin
          if (rspNonZero) begin
            strb.latchCode = 1'b1;
            stateNext = (!secondWait && rspIsFail) ? S_REARM : S_PARAM;
          end else if (budgetOut) begin
            if (secondWait) begin
              stateNext = S_PARAM;
            end else begin
              strb.setTimeout = 1'b1;
              strb.loadRetry  = 1'b1;
              secondSet       = 1'b1;
              strb.loadGap    = !ivlZero;
              stateNext       = ivlZero ? S_POST_RD : S_POST_GAP;
            end
          end else begin
            strb.decRetry = !noTimeout;
            strb.loadGap  = !ivlZero;
            stateNext     = ivlZero ? S_POST_RD : S_POST_GAP;
          end
        end
      end
      S_POST_GAP: begin
        if (gapZero) stateNext = S_POST_RD;
        else strb.decGap = 1'b1;
      end
      S_REARM: begin
        strb.op = OP_WR_REARM;
        if (busReady) stateNext = S_DONE;
      end
      S_PARAM: begin
        strb.op = OP_RD_ARG;
        if (busReady) begin
          strb.latchResult = 1'b1;
          stateNext        = S_DONE;
        end
      end
      S_DONE: begin
        doneValid = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busValid = (strb.op != OP_NONE);

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R9: an absent controller completes in the next cycle
  assert_absent_fast_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !present) |=> doneValid);

  // R9: no bus activity while waiting for a request
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busValid);

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CODE_W = 8,
  parameter int CMD_W  = 8,
  parameter int IVL_W  = 16,
  parameter int RTY_W  = 24,
  parameter logic [ADDR_W-1:0] MSG_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] ARG_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] RSP_ADDR = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [DATA_W-1:0] reqArg,
  input  logic              present,
  input  logic              noTimeout,
  input  logic [IVL_W-1:0]  pollInterval,
  input  logic [RTY_W-1:0]  pollRetries,
  output logic              busValid,
  input  logic              busReady,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              doneValid,
  output logic [CODE_W-1:0] doneCode,
  output logic [DATA_W-1:0] doneResult,
  output logic              doneTimeout
);

  ctlStrobes_t strb;
  logic retryZero, gapZero, ivlZero, rspNonZero, rspIsFail;

  mbox_seq_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .present    (present),
    .noTimeout  (noTimeout),
    .busReady   (busReady),
    .busValid   (busValid),
    .retryZero  (retryZero),
    .gapZero    (gapZero),
    .ivlZero    (ivlZero),
    .rspNonZero (rspNonZero),
    .rspIsFail  (rspIsFail),
    .doneValid  (doneValid),
    .strb       (strb)
  );

  mbox_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .CMD_W(CMD_W),
    .IVL_W(IVL_W), .RTY_W(RTY_W),
    .MSG_ADDR(MSG_ADDR), .ARG_ADDR(ARG_ADDR), .RSP_ADDR(RSP_ADDR)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqCmd       (reqCmd),
    .reqArg       (reqArg),
    .pollInterval (pollInterval),
    .pollRetries  (pollRetries),
    .busRdata     (busRdata),
    .busWrite     (busWrite),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .retryZero    (retryZero),
    .gapZero      (gapZero),
    .ivlZero      (ivlZero),
    .rspNonZero   (rspNonZero),
    .rspIsFail    (rspIsFail),
    .doneCode     (doneCode),
    .doneResult   (doneResult),
    .doneTimeout  (doneTimeout)
  );

  // R11: a stalled request holds its address, direction and data
  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) &&
                                 $stable(busWrite) && $stable(busWdata)));

endmodule

// File: tb/tb_mbox_cmd_seq.sv
`timescale 1ns/1ps
module tb_mbox_cmd_seq;

  localparam logic [7:0] A_MSG = 8'h10;
  localparam logic [7:0] A_ARG = 8'h14;
  localparam logic [7:0] A_RSP = 8'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqCmd = '0;
  logic [31:0] reqArg = '0;
  logic        present = 1'b1;
  logic        noTimeout = 1'b0;
  logic [15:0] pollInterval = '0;
  logic [23:0] pollRetries = '0;
  logic        busValid;
  logic        busReady = 1'b1;
  logic        busWrite;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        doneValid;
  logic [7:0]  doneCode;
  logic [31:0] doneResult;
  logic        doneTimeout;

  always #2 clk = ~clk;

  mbox_cmd_seq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqArg(reqArg), .present(present), .noTimeout(noTimeout),
    .pollInterval(pollInterval), .pollRetries(pollRetries),
    .busValid(busValid), .busReady(busReady), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .doneValid(doneValid), .doneCode(doneCode), .doneResult(doneResult),
    .doneTimeout(doneTimeout)
  );

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  // controller model
  logic [31:0] devRsp = 32'h1;
  logic [31:0] devArg = '0;
  int          zeroCnt = 0;
  int          postBusy = 0;
  logic [31:0] finalCode = 32'h1;
  logic [7:0]  wAddr [0:7];
  logic [31:0] wData [0:7];
  int          nWr = 0;
  int          rdTime [0:31];
  int          nRspRd = 0;
  int          nParRd = 0;
  logic        stall = 1'b0;
  logic [7:0]  lfsr = 8'h5B;

  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    if (busAddr == A_ARG) busRdata = devArg;
    else if (busAddr == A_RSP) busRdata = (zeroCnt > 0) ? 32'h0 : devRsp;
    else busRdata = 32'h0;
  end

  always @(posedge clk) begin
    if (busValid && busReady) begin
      if (busWrite) begin
        if (nWr < 8) begin
          wAddr[nWr] <= busAddr;
          wData[nWr] <= busWdata;
        end
        nWr <= nWr + 1;
        if (busAddr == A_RSP) devRsp <= busWdata;
        if (busAddr == A_ARG) devArg <= busWdata;
        if (busAddr == A_MSG) begin
          devRsp  <= finalCode;
          zeroCnt <= postBusy;
          devArg  <= devArg ^ 32'h5A00_0000 ^ busWdata;
        end
      end else if (busAddr == A_RSP) begin
        if (nRspRd < 32) rdTime[nRspRd] <= cyc;
        nRspRd <= nRspRd + 1;
        if (zeroCnt > 0) zeroCnt <= zeroCnt - 1;
      end else if (busAddr == A_ARG) begin
        nParRd <= nParRd + 1;
      end
    end
  end

  always @(negedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    busReady <= !stall || lfsr[0];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
  endtask

  task automatic runCmd(input logic [7:0] cmd, input logic [31:0] arg,
                        input int p, input int q, input logic [7:0] code,
                        input logic [31:0] preVal, input int ivl, input int rty,
                        input bit noTo);
    int preReads, postReads, expWr, waitN, base;
    bit preTo, postTo, rearm, readyBad, spaceBad;
    logic [7:0]  expCode;
    logic [31:0] expRes;
    // expected behaviour from the requirements
    if (noTo) begin
      preReads = p + 1; preTo = 0;
    end else if (p <= rty) begin
      preReads = p + 1; preTo = 0;
    end else begin
      preReads = rty + 1; preTo = 1;
    end
    postReads = 0; postTo = 0; rearm = 0; expCode = 8'h00;
    if (!preTo) begin
      if (noTo || (code != 0 && q <= rty)) begin
        postReads = q + 1; expCode = code;
        rearm = (code == 8'hFF);
      end else begin
        postTo = 1;
        if (code != 0 && (q - (rty + 1)) <= rty) begin
          postReads = q + 1; expCode = code;
        end else begin
          postReads = 2 * (rty + 1); expCode = 8'h00;
        end
      end
    end
    expWr  = preTo ? 0 : (rearm ? 4 : 3);
    expRes = (preTo || rearm) ? 32'h0 : (arg ^ 32'h5A00_0000 ^ {24'h0, cmd});

    @(negedge clk);
    pollInterval = 16'(ivl);
    pollRetries  = 24'(rty);
    noTimeout    = noTo;
    devRsp = preVal; devArg = '0; zeroCnt = p; postBusy = q;
    finalCode = {24'h0, code};
    nWr = 0; nRspRd = 0; nParRd = 0;
    reqValid = 1'b1; reqCmd = cmd; reqArg = arg;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    waitN = 0; readyBad = 0;
    while (!doneValid && waitN < 5000) begin
      if (reqReady) readyBad = 1;
      @(negedge clk);
      waitN++;
    end
    chk(doneValid, "R10", "done seen", {31'h0, doneValid}, 32'h1);
    chk(!readyBad && !reqReady, "R10", "reqReady low in flight", {31'h0, readyBad}, 32'h0);
    if (preTo) begin
      chk(doneTimeout && doneCode == 0 && doneResult == 0 && nWr == 0 && nParRd == 0,
          "R3", "pre timeout result/code/writes", {doneResult[15:0], doneCode, 7'h0, doneTimeout},
          {16'h0, 8'h00, 8'h01});
    end else begin
      chk(doneCode == expCode, rearm ? "R6" : (postTo ? "R7" : "R5"), "doneCode",
          {24'h0, doneCode}, {24'h0, expCode});
      chk(doneResult == expRes, rearm ? "R6" : "R5", "doneResult", doneResult, expRes);
      chk(doneTimeout == postTo, "R7", "doneTimeout", {31'h0, doneTimeout}, {31'h0, postTo});
      chk(nParRd == (rearm ? 0 : 1), rearm ? "R6" : "R5", "parameter reads",
          32'(nParRd), rearm ? 32'h0 : 32'h1);
      chk(nWr == expWr, "R4", "write count", 32'(nWr), 32'(expWr));
      chk(wAddr[0] == A_RSP && wData[0] == 0 && wAddr[1] == A_ARG && wData[1] == arg &&
          wAddr[2] == A_MSG && wData[2] == {24'h0, cmd}, "R4", "issue order",
          {wAddr[0], wAddr[1], wAddr[2], 8'h0}, {A_RSP, A_ARG, A_MSG, 8'h0});
      if (rearm)
        chk(wAddr[3] == A_RSP && wData[3] == 32'h1, "R6", "re-arm write", wData[3], 32'h1);
    end
    chk(nRspRd == preReads + postReads, noTo ? "R8" : "R2", "response reads",
        32'(nRspRd), 32'(preReads + postReads));
    if (!stall) begin
      spaceBad = 0;
      for (int k = 1; k < preReads && k < 32; k++)
        if (rdTime[k] - rdTime[k-1] != ivl + 1) spaceBad = 1;
      base = preReads;
      for (int k = base + 1; k < base + postReads && k < 32; k++)
        if (rdTime[k] - rdTime[k-1] != ivl + 1) spaceBad = 1;
      chk(!spaceBad, "R2", "poll spacing", {31'h0, spaceBad}, 32'h0);
    end else begin
      chk(1'b1, "R11", "stalled run completed", 32'h0, 32'h0);
    end
    @(negedge clk);
    chk(!doneValid && reqReady, "R10", "pulse ends, ready back",
        {30'h0, doneValid, reqReady}, 32'h1);
  endtask

  task automatic runAbsent(input logic [7:0] cmd, input logic [31:0] arg);
    @(negedge clk);
    present = 1'b0;
    nWr = 0; nRspRd = 0; nParRd = 0;
    reqValid = 1'b1; reqCmd = cmd; reqArg = arg;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(doneValid && doneCode == 8'h01 && doneResult == 0 && !doneTimeout, "R9",
        "absent completion", {doneResult[15:0], doneCode, 6'h0, doneValid, doneTimeout},
        {16'h0, 8'h01, 8'h02});
    @(negedge clk);
    chk(nWr == 0 && nRspRd == 0 && nParRd == 0, "R9", "absent bus traffic",
        32'(nWr + nRspRd + nParRd), 32'h0);
    present = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] codes [0:4];
    int idx;
    codes[0] = 8'h01; codes[1] = 8'hFF; codes[2] = 8'hFE;
    codes[3] = 8'hFD; codes[4] = 8'hFC;
    repeat (3) @(negedge clk);
    chk(reqReady && !doneValid && !busValid, "R1", "reset outputs",
        {29'h0, reqReady, doneValid, busValid}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !doneValid && !busValid, "R1", "after reset release",
        {29'h0, reqReady, doneValid, busValid}, 32'h4);

    idx = 0;
    foreach (codes[c]) begin
      for (int iv = 0; iv < 3; iv++) begin
        for (int p = 0; p < 4; p++) begin
          for (int qi = 0; qi < 4; qi++) begin
            int q;
            q = (qi == 0) ? 0 : (qi == 1) ? 1 : (qi == 2) ? 3 : 5;
            idx++;
            runCmd(8'(idx * 7 + 3), 32'h1234_0000 + 32'(idx * 977), p, q, codes[c],
                   32'h1, (iv == 2) ? 3 : iv, 2, 1'b0);
          end
        end
      end
    end

    // R7: controller never answers after the trigger
    runCmd(8'h21, 32'hCAFE_0001, 0, 0, 8'h00, 32'h1, 0, 1, 1'b0);
    runCmd(8'h22, 32'hCAFE_0002, 1, 2, 8'h00, 32'h1, 2, 1, 1'b0);
    // R2: a non-OK idle value still counts as idle
    runCmd(8'h23, 32'hBEEF_0003, 1, 0, 8'h01, 32'hFC, 1, 2, 1'b0);
    // R8: unlimited polling past the budget
    runCmd(8'h24, 32'hBEEF_0004, 5, 4, 8'h01, 32'h1, 1, 0, 1'b1);
    runCmd(8'h25, 32'hBEEF_0005, 7, 0, 8'hFD, 32'h1, 0, 1, 1'b1);
    // R9: absent controller
    runAbsent(8'h30, 32'hFFFF_FFFF);
    runAbsent(8'h31, 32'h0000_0001);
    // R11: random stalls must not change results
    stall = 1'b1;
    for (int s = 0; s < 12; s++)
      runCmd(8'(s + 64), 32'h7700_0000 + 32'(s), s % 4, (s * 3) % 6,
             codes[s % 5], 32'h1, s % 3, 2, 1'b0);
    stall = 1'b0;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule